// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit

This unit performs signed 32-bit arithmetic in which an overflowing result is pinned to the nearest representable limit instead of wrapping around. It offers four operations: plain add, plain subtract, and two "doubling" forms. A doubling form first multiplies the second operand by two with its own saturation, then adds that value to the first operand, or subtracts it from the first operand, again with saturation.

Each clamp, in either stage, raises a one-cycle saturation strobe. A surrounding datapath ORs this strobe into bit 27 of its status word, which acts as a sticky overflow flag. The status word itself is not part of this unit. A datapath that drives this unit from its register file can take the first operand's register index from instruction bits 3:0, the second from bits 19:16 and the destination from bits 15:12. Only the 2-bit operation select reaches this unit.

The arithmetic is one combinational pass. The parameter `OUT_REG` selects whether the result and strobe leave through a register stage (the default) or directly. The unit has no control states: the only sequential element is the optional output stage, which has two conditions. It is held clear while reset is asserted, and it captures new values on every clock edge once reset is released.

Top module: `sat_alu`

## Requirements
- R1: Operation select encoding: 0 = add, 1 = subtract (first minus second), 2 = doubling add, 3 = doubling subtract. Bit 1 chooses doubling and bit 0 chooses subtraction.
- R2: Add: when the signed sum of `op_a` and `op_b` fits in 32 bits, `result` is that sum and `q_set` is 0.
- R3: Subtract: when `op_a - op_b` fits in 32 bits, `result` is that difference and `q_set` is 0.
- R4: On signed overflow in the final add or subtract, `result` becomes 0x7FFFFFFF if the true value is positive and 0x80000000 if it is negative, and `q_set` is 1.
- R5: Doubling stage: when bits 31 and 30 of `op_b` differ, the doubled value is 0x80000000 for a negative `op_b` and 0x7FFFFFFF for a non-negative `op_b`, and `q_set` is 1. Otherwise the doubled value is `op_b` shifted left by one.
- R6: The doubling forms feed the doubled value into the saturating add or subtract. When both stages saturate, `q_set` is a single 1 and the final clamp determines `result`.
- R7: With `OUT_REG` = 1, `result` and `q_set` reflect the inputs present at the previous rising clock edge. While `rst_n` is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand (the one doubled) |
| op_sel | input | 2 | Operation select, encoded as in R1 |
| result | output | 32 | Saturated signed result |
| q_set | output | 1 | High when any stage clamped |

## Verification
The only internal state is the output register, so a fault in the unit shows up one clock later as a wrong value on `result` or on `q_set`. A wrong clamp direction or a missed overflow detection lands exactly at the signed limits. A strobe that is lost in the doubling stage only shows when the final stage does not saturate. The directed cases therefore include doubling of 0x40000000 and 0xBFFFFFFF against small first operands, and overflows of one step past either limit. Random operands cover the ordinary values in between.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_DADD = 2'd2,
        OP_DSUB = 2'd3
    } sat_op_e;
endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dbl_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        sat_o = val_i[W-1] ^ val_i[W-2];
        if (sat_o)
            dbl_o = val_i[W-1] ? MINV : MAXV;
        else
            dbl_o = {val_i[W-2:0], 1'b0};
    end

    // R5: a clamped doubling lands on the limit that matches the operand's sign
    assert_dbl_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (dbl_o == (val_i[W-1] ? MINV : MAXV)));
    // R5: an unclamped doubling keeps the operand's sign
    assert_dbl_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sat_o |-> (dbl_o[W-1] == val_i[W-1]));
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] b_eff;
    logic [W-1:0] wrapped;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        wrapped = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        sat_o   = (a_i[W-1] == b_eff[W-1]) && (wrapped[W-1] != a_i[W-1]);
        if (sat_o)
            res_o = wrapped[W-1] ? MAXV : MINV;
        else
            res_o = wrapped;
    end

    // R4: a clamp always lands on one of the two limits
    assert_clamp_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (res_o == MAXV || res_o == MINV));
    // R4: overflow can only go in the direction of the first operand's sign
    assert_clamp_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (res_o[W-1] == a_i[W-1]));
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result,
    output logic         q_set
);
    import sat_pkg::*;

    sat_op_e      op;
    logic         use_dbl;
    logic         use_sub;
    logic [W-1:0] dbl_val;
    logic         dbl_sat;
    logic [W-1:0] rhs;
    logic [W-1:0] fin_val;
    logic         fin_sat;
    logic         q_next;

    always_comb begin
        op      = sat_op_e'(op_sel);
        use_dbl = (op == OP_DADD) || (op == OP_DSUB);
        use_sub = (op == OP_SUB)  || (op == OP_DSUB);
        rhs     = use_dbl ? dbl_val : op_b;
        q_next  = (use_dbl && dbl_sat) || fin_sat;
    end

    sat_doubler #(.W(W)) u_dbl (
        .clk(clk), .rst_n(rst_n), .val_i(op_b), .dbl_o(dbl_val), .sat_o(dbl_sat)
    );

    sat_addsub #(.W(W)) u_fin (
        .clk(clk), .rst_n(rst_n), .a_i(op_a), .b_i(rhs), .sub_i(use_sub),
        .res_o(fin_val), .sat_o(fin_sat)
    );

    generate
        if (OUT_REG) begin : g_reg
            logic [W-1:0] res_q;
            logic         q_q;
            logic         primed;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q  <= '0;
                    q_q    <= 1'b0;
                    primed <= 1'b0;
                end else begin
                    res_q  <= fin_val;
                    q_q    <= q_next;
                    primed <= 1'b1;
                end
            end

            assign result = res_q;
            assign q_set  = q_q;

            // R7: registered outputs follow the previous cycle's arithmetic
            assert_reg_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
                primed |-> (q_set == $past(q_next) && result == $past(fin_val)));
            // R6: a saturated doubling stage alone still raises the strobe
            assert_dbl_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (use_dbl && dbl_sat) |=> q_set);
        end else begin : g_comb
            assign result = fin_val;
            assign q_set  = q_next;
        end
    endgenerate
endmodule

// File: tb/sat_alu_test.sv
module sat_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  op_sel = '0;
    logic [31:0] result;
    logic        q_set;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sat_alu #(.W(32), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .result(result), .q_set(q_set)
    );

    function automatic longint clamp64(longint v, output bit hit);
        hit = 1'b0;
        if (v > 64'sd2147483647) begin hit = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483648) begin hit = 1'b1; return -64'sd2147483648; end
        return v;
    endfunction

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] sel,
                                  output logic [31:0] r, output bit q);
        longint la, lb, v;
        bit h1, h2;
        la = longint'($signed(a));
        lb = longint'($signed(b));
        h1 = 1'b0;
        if (sel[1]) lb = clamp64(lb * 2, h1);
        v = sel[0] ? la - lb : la + lb;
        v = clamp64(v, h2);
        r = v[31:0];
        q = h1 | h2;
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sel, input string req);
        logic [31:0] er;
        bit eq;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = sel;
        model(a, b, sel, er, eq);
        @(negedge clk);
        checks++;
        if (result !== er || q_set !== eq) begin
            errors++;
            $display("FAIL %s: a=%h b=%h sel=%0d got %h/q%0b expected %h/q%0b",
                     req, a, b, sel, result, q_set, er, eq);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        op_a = 32'h7FFFFFFF; op_b = 32'h1; op_sel = 2'd0;
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || q_set !== 1'b0) begin
            errors++;
            $display("FAIL R7: reset outputs got %h/q%0b expected 00000000/q0", result, q_set);
        end
        rst_n = 1'b1;

        run(32'h0, 32'h0, 2'd0, "R2 zero add");
        run(32'h0, 32'h0, 2'd3, "R1 zero doubling sub");
        run(32'h12345678, 32'h11111111, 2'd0, "R2 add");
        run(32'h00000005, 32'h00000009, 2'd1, "R3 sub");
        run(32'h7FFFFFFF, 32'h1, 2'd0, "R4 add positive clamp");
        run(32'h80000000, 32'h1, 2'd1, "R4 sub negative clamp");
        run(32'h80000000, 32'hFFFFFFFF, 2'd0, "R4 add negative clamp");
        run(32'h00000001, 32'h80000000, 2'd1, "R4 sub positive clamp");
        run(32'h0, 32'h40000000, 2'd2, "R5 doubling 0x40000000");
        run(32'h0, 32'hBFFFFFFF, 2'd2, "R5 doubling 0xBFFFFFFF");
        run(32'h00000010, 32'h40000000, 2'd3, "R5 doubling sub");
        run(32'h0, 32'h20000000, 2'd2, "R5 plain shift");
        run(32'h7FFFFFFF, 32'h40000000, 2'd2, "R6 both stages");
        run(32'h80000000, 32'h40000000, 2'd3, "R6 both stages sub");
        run(32'hC0000000, 32'h40000000, 2'd2, "R6 dbl only");

        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            logic [1:0] s;
            a = $urandom();
            b = $urandom();
            s = 2'($urandom());
            if (i % 5 == 0) a = {a[31], {31{~a[31]}}} ^ 32'($urandom_range(0, 3));
            run(a, b, s, "R1 random");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R7: watchdog expired got hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule